// File: doc/BRIEF.md
# Load-or-Shift Register with J/K-bar Head Stage

This block is a small register of `WIDTH` stages (four by default) that either takes a whole word from its parallel inputs or moves its contents one place along per clock, from the head stage (`stageOut[0]`) toward the tail stage (`stageOut[WIDTH-1]`). A single select line picks the mode. An active-low clear empties it at any moment, without waiting for a clock.

In shift mode, the head stage does not take a plain serial bit. It is fed by a J input and an inverted-K input. Depending on how that pair is wired, the head acts as a JK, D or T flip-flop. Every stage is visible on the outputs. The inverse of the tail stage is also driven, so a following stage can use either polarity.

Top module: `jkload_shifter`

## Requirements
- R1: While `clrN` is low, every stage reads 0 at once, without any clock edge, and neither loading nor shifting can change that.
- R2: With `shiftMode` = 0, a rising `clk` edge stores `parIn[i]` into stage i. `jIn` and `kBarIn` have no effect.
- R3: With `shiftMode` = 1, a rising edge gives stage i (i ≥ 1) the value stage i-1 held before that edge. All stages update together.
- R4: In shift mode with `jIn`=0 and `kBarIn`=0, the head stage becomes 0.
- R5: In shift mode with `jIn`=1 and `kBarIn`=1, the head stage becomes 1.
- R6: In shift mode with `jIn`=0 and `kBarIn`=1, the head stage keeps its previous value.
- R7: In shift mode with `jIn`=1 and `kBarIn`=0, the head stage takes the inverse of its previous value.
- R8: `tailBarOut` always equals the inverse of `stageOut[WIDTH-1]`.
- R9: While `clrN` is high, changing any data or mode input between rising edges leaves every stage unchanged.
- R10: After `clrN` returns high, the first rising edge loads or shifts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Asynchronous clear, active low |
| shiftMode | input | 1 | 1 = shift toward the tail, 0 = parallel load |
| parIn | input | WIDTH | Parallel data, bit i goes to stage i |
| jIn | input | 1 | J input of the head stage |
| kBarIn | input | 1 | Inverted-K input of the head stage |
| stageOut | output | WIDTH | Stage values, bit 0 is the head stage |
| tailBarOut | output | 1 | Inverse of the tail stage |

## Verification
Clear and a clock edge can land in the same cycle. A load or shift would then compete with the clear for the stages. The bench drops `clrN` in the middle of a cycle and first checks, before any edge, that the stages are empty. It keeps clear low across a rising edge while a load of all ones is requested, and the stages must still read zero after that edge. It then releases clear and checks that the very next edge loads a new word.

// File: rtl/jkshift_pkg.sv
package jkshift_pkg;
  // Strobes from the control decode into the stage datapath
  typedef struct packed {
    logic loadStb;   // take the parallel word
    logic shiftStb;  // move toward the tail
    logic headNext;  // value the head stage takes on a shift
  } stageCtl_t;
endpackage

// File: rtl/jkshift_ctrl.sv
module jkshift_ctrl
  import jkshift_pkg::*;
(
  input  logic      clk,
  input  logic      clrN,
  input  logic      shiftMode,
  input  logic      jIn,
  input  logic      kBarIn,
  input  logic      headQ,
  output stageCtl_t ctl
);

  logic headFromJk;

  // J/K-bar decode for the head stage
  always_comb begin
    unique case ({jIn, kBarIn})
      2'b00:   headFromJk = 1'b0;
      2'b11:   headFromJk = 1'b1;
      2'b01:   headFromJk = headQ;
      default: headFromJk = ~headQ;
    endcase
  end

  always_comb begin
    ctl.loadStb  = ~shiftMode;
    ctl.shiftStb = shiftMode;
    ctl.headNext = headFromJk;
  end

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!clrN)
    (shiftMode && !jIn && kBarIn) |=> (headQ == $past(headQ))); // R6

  AST_HEAD_TOGGLE: assert property (@(posedge clk) disable iff (!clrN)
    (shiftMode && jIn && !kBarIn) |=> (headQ != $past(headQ))); // R7

  AST_HEAD_SET: assert property (@(posedge clk) disable iff (!clrN)
    (shiftMode && jIn && kBarIn) |=> headQ); // R5

  AST_HEAD_RESET: assert property (@(posedge clk) disable iff (!clrN)
    (shiftMode && !jIn && !kBarIn) |=> !headQ); // R4

endmodule

// File: rtl/jkshift_dp.sv
module jkshift_dp
  import jkshift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  stageCtl_t        ctl,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shiftSrc;
  logic [WIDTH-1:0] stageNext;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shiftSrc[i] = ctl.headNext;
    end else begin : g_body
      assign shiftSrc[i] = stageQ[i-1];
    end
    assign stageNext[i] = ctl.loadStb  ? parIn[i]    :
                          ctl.shiftStb ? shiftSrc[i] : stageQ[i];
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stageQ <= '0;
    else       stageQ <= stageNext;
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clrN)
    ctl.loadStb |=> (stageQ == $past(parIn))); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clrN)
    ctl.shiftStb |=> (stageQ[LAST:1] == $past(stageQ[LAST-1:0]))); // R3

  always_ff @(posedge clk) begin
    if (!clrN) begin
      AST_CLEAR_EMPTY: assert (stageQ == '0)
        else $error("stages not empty under clear"); // R1
    end
  end

endmodule

// File: rtl/jkload_shifter.sv
module jkload_shifter
  import jkshift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             shiftMode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             jIn,
  input  logic             kBarIn,
  output logic [WIDTH-1:0] stageOut,
  output logic             tailBarOut
);

  stageCtl_t ctl;

  jkshift_ctrl u_ctrl (
    .clk       (clk),
    .clrN      (clrN),
    .shiftMode (shiftMode),
    .jIn       (jIn),
    .kBarIn    (kBarIn),
    .headQ     (stageOut[0]),
    .ctl       (ctl)
  );

  jkshift_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .clrN   (clrN),
    .ctl    (ctl),
    .parIn  (parIn),
    .stageQ (stageOut)
  );

  assign tailBarOut = ~stageOut[WIDTH-1];

endmodule

// File: tb/jkload_shifter_tb.sv
module jkload_shifter_tb;

  logic       clk = 1'b0;
  logic       clrN = 1'b1;
  logic       shiftMode = 1'b0;
  logic [3:0] parIn = 4'd0;
  logic       jIn = 1'b0;
  logic       kBarIn = 1'b0;
  logic [3:0] stageOut;
  logic       tailBarOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  jkload_shifter #(.WIDTH(4)) u_dut (
    .clk(clk), .clrN(clrN), .shiftMode(shiftMode), .parIn(parIn),
    .jIn(jIn), .kBarIn(kBarIn), .stageOut(stageOut), .tailBarOut(tailBarOut)
  );

  always #5 clk = ~clk;

  // {shiftMode, jIn, kBarIn, parIn[3:0], expected stageOut[3:0]}; bit 0 is the head stage
  localparam int NVEC = 13;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0_10_1011_1011,  // load, J/K-bar ignored         R2
    11'b1_11_1010_0111,  // shift, head set               R3 R5
    11'b1_00_0101_1110,  // shift, head reset             R4
    11'b1_01_0000_1100,  // shift, head holds 0           R6
    11'b1_10_1111_1001,  // shift, head toggles 0->1      R7
    11'b1_10_0000_0010,  // shift, head toggles 1->0      R7
    11'b1_01_0000_0100,  // shift, head holds 0           R6
    11'b0_00_0110_0110,  // load                          R2
    11'b1_01_0000_1100,  // shift, hold                   R6
    11'b1_11_0000_1001,  // shift, set                    R5
    11'b1_01_0000_0011,  // shift, head holds 1           R6
    11'b0_11_1111_1111,  // load all ones                 R2
    11'b1_00_0000_1110   // shift, reset                  R4
  };
  localparam string TAG [NVEC] = '{
    "R2", "R3 R5", "R3 R4", "R3 R6", "R3 R7", "R3 R7", "R3 R6",
    "R2", "R3 R6", "R3 R5", "R3 R6", "R2", "R3 R4"
  };

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s stageOut actual=%b expected=%b", tag, act, exp);
    end
    checks++;
    if (tailBarOut !== ~exp[3]) begin
      errors++;
      $display("FAIL R8 (%s) tailBarOut actual=%b expected=%b", tag, tailBarOut, ~exp[3]);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2 clrN = 1'b0;
    @(negedge clk);
    chk(stageOut, 4'b0000, "R1 reset state");
    // clear held across an edge while a load is requested
    shiftMode = 1'b0; parIn = 4'b1111;
    @(negedge clk);
    chk(stageOut, 4'b0000, "R1 clear overrides load");
    clrN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      shiftMode = VEC[v][10];
      jIn       = VEC[v][9];
      kBarIn    = VEC[v][8];
      parIn     = VEC[v][7:4];
      @(negedge clk);
      chk(stageOut, VEC[v][3:0], TAG[v]);
    end

    // R9: inputs changed between edges must not move the stages (state 1110)
    shiftMode = 1'b1; jIn = 1'b1; kBarIn = 1'b0;
    #2;
    shiftMode = 1'b0; parIn = 4'b0001; jIn = 1'b0;
    #2;
    chk(stageOut, 4'b1110, "R9 no edge");
    @(negedge clk);
    chk(stageOut, 4'b0001, "R2 load after R9");

    // R1: clear in mid-cycle takes effect with no edge
    #2 clrN = 1'b0;
    #1;
    chk(stageOut, 4'b0000, "R1 async clear");
    shiftMode = 1'b0; parIn = 4'b1111;
    @(negedge clk);
    chk(stageOut, 4'b0000, "R1 clear held over edge");

    // R10: first edge after release loads normally
    clrN = 1'b1; parIn = 4'b0101;
    @(negedge clk);
    chk(stageOut, 4'b0101, "R10 first edge load");
    shiftMode = 1'b1; jIn = 1'b1; kBarIn = 1'b0;
    @(negedge clk);
    chk(stageOut, 4'b1010, "R10 R7 shift with toggle");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule